// File: doc/BRIEF.md
# Floating-Point Quiet Compare with Predicate Flag

This unit compares two IEEE-754 operands, either both single precision (taken from the low 32 bits of each 64-bit bus) or both double precision, and reduces the outcome to one of four relations: less, equal, greater or unordered. The compare is quiet. A NaN of either kind makes the result unordered, but only a signalling NaN raises the invalid-exception pulse.

A 3-bit predicate code picks one of eight conditions on the relation. The outcome is registered as a condition flag. It is also merged into a status word: the caller's low status bits are kept, the four top bits are cleared, and the flag is placed in bit 29. All three outputs change on the clock edge that samples the valid strobe. Without a strobe, the flag and status word hold their values and the invalid pulse stays low.

Top module: `fp_cmp_pred`

## Requirements
- R1: While reset (active low) is asserted, and right after it is released, `cond_flag`, `stat_out` and `invalid_pulse` are all zero.
- R2: The relation is less, equal, greater or unordered. +0 and −0 compare equal, and equal bit patterns compare equal.
- R3: Predicate codes: 0 never holds, 1 unordered, 2 equal, 3 unordered or equal, 4 less, 5 unordered or less, 6 less or equal, 7 anything but greater. The flag is 1 only when the selected predicate holds.
- R4: The new status word is {2'b00, flag, 1'b0, stat_keep[27:0]}. Bits 31, 30 and 28 are zero, bit 29 equals `cond_flag`, and bits 27:0 are the `stat_keep` value sampled with the strobe.
- R5: An operand with an all-ones exponent and a non-zero fraction is a NaN and gives unordered. If the fraction's top bit is 0 (signalling), `invalid_pulse` is 1 for exactly the one cycle after the strobe. A quiet NaN leaves it at 0.
- R6: With `dbl_sel`=0, only bits 31:0 of each operand count. Bits 63:32 have no effect on the result.
- R7: Non-NaN operands are ordered by sign and magnitude. A negative operand is below a positive one, and when both are negative the larger magnitude is the smaller value.
- R8: Outputs update on the clock edge where `cmp_valid` is 1. With `cmp_valid`=0, `cond_flag` and `stat_out` hold and `invalid_pulse` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmp_valid | input | 1 | Strobe: sample operands and update outputs |
| dbl_sel | input | 1 | 1 = double precision, 0 = single (low 32 bits) |
| pred_code | input | 3 | Predicate selector |
| opa | input | 64 | First operand |
| opb | input | 64 | Second operand |
| stat_keep | input | 28 | Status bits carried unchanged into the new status word |
| cond_flag | output | 1 | Registered predicate result |
| stat_out | output | 32 | Registered updated status word |
| invalid_pulse | output | 1 | One-cycle pulse for a signalling NaN operand |

## Verification
The invalid-exception pulse and the flag/status update can land in the same cycle. A strobed compare with a signalling NaN, under a predicate that accepts unordered, must set the flag and raise the pulse on the same edge. The bench provokes this with signalling NaNs on either operand in both precisions, issued back to back with quiet-NaN and ordered compares. Its reference model predicts all three outputs for every edge, so a pulse that is missing, lingers, or is raised by a quiet NaN shows up in the next cycle's comparison.

// File: rtl/fp_cmp_pred.sv
module fp_cmp_pred #(
  parameter int KEEP_W = 28
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmp_valid,
  input  logic              dbl_sel,
  input  logic [2:0]        pred_code,
  input  logic [63:0]       opa,
  input  logic [63:0]       opb,
  input  logic [KEEP_W-1:0] stat_keep,
  output logic              cond_flag,
  output logic [KEEP_W+3:0] stat_out,
  output logic              invalid_pulse
);
  localparam int STAT_W = KEEP_W + 4;

  typedef enum logic [1:0] {REL_LT, REL_EQ, REL_GT, REL_UN} rel_t;

  logic        sgn_a, sgn_b, nan_a, nan_b, snan_a, snan_b;
  logic [62:0] mag_a, mag_b;
  rel_t        rel;
  logic        hit;

  assign sgn_a = dbl_sel ? opa[63] : opa[31];
  assign sgn_b = dbl_sel ? opb[63] : opb[31];
  assign mag_a = dbl_sel ? opa[62:0] : {32'd0, opa[30:0]};
  assign mag_b = dbl_sel ? opb[62:0] : {32'd0, opb[30:0]};

  assign nan_a = dbl_sel ? (&opa[62:52] && |opa[51:0]) : (&opa[30:23] && |opa[22:0]);
  assign nan_b = dbl_sel ? (&opb[62:52] && |opb[51:0]) : (&opb[30:23] && |opb[22:0]);
  assign snan_a = nan_a && !(dbl_sel ? opa[51] : opa[22]);
  assign snan_b = nan_b && !(dbl_sel ? opb[51] : opb[22]);

  always_comb begin
    if (nan_a || nan_b)                              rel = REL_UN;
    else if ((mag_a == 63'd0 && mag_b == 63'd0) ||
             (sgn_a == sgn_b && mag_a == mag_b))     rel = REL_EQ;
    else if (sgn_a != sgn_b)                         rel = sgn_a ? REL_LT : REL_GT;
    else if (!sgn_a)                                 rel = (mag_a < mag_b) ? REL_LT : REL_GT;
    else                                             rel = (mag_a < mag_b) ? REL_GT : REL_LT;
  end

  always_comb begin
    case (pred_code)
      3'd0:    hit = 1'b0;
      3'd1:    hit = (rel == REL_UN);
      3'd2:    hit = (rel == REL_EQ);
      3'd3:    hit = (rel == REL_UN) || (rel == REL_EQ);
      3'd4:    hit = (rel == REL_LT);
      3'd5:    hit = (rel == REL_UN) || (rel == REL_LT);
      3'd6:    hit = (rel == REL_LT) || (rel == REL_EQ);
      default: hit = (rel != REL_GT);
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cond_flag     <= 1'b0;
      stat_out      <= '0;
      invalid_pulse <= 1'b0;
    end else begin
      invalid_pulse <= cmp_valid && (snan_a || snan_b);
      if (cmp_valid) begin
        cond_flag <= hit;
        stat_out  <= {2'b00, hit, 1'b0, stat_keep};
      end
    end
  end

  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !cmp_valid |=> $stable(cond_flag) && $stable(stat_out) && !invalid_pulse);

  p_status_form_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_valid |=> stat_out[KEEP_W-1:0] == $past(stat_keep) &&
                  stat_out[STAT_W-1 -: 2] == 2'b00 && !stat_out[KEEP_W] &&
                  stat_out[KEEP_W+1] == cond_flag);

  p_never_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_valid && pred_code == 3'd0) |=> !cond_flag);

  p_snan_unordered_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_valid && pred_code == 3'd1) |=> (invalid_pulse |-> cond_flag));

  p_zero_equal_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_valid && dbl_sel && pred_code == 3'd2 && opa[62:0] == 63'd0 && opb[62:0] == 63'd0)
      |=> cond_flag);
endmodule

// File: tb/test_fp_cmp_pred.sv
module test_fp_cmp_pred;
  logic        clk = 1'b0;
  logic        rst_n, cmp_valid, dbl_sel;
  logic [2:0]  pred_code;
  logic [63:0] opa, opb;
  logic [27:0] stat_keep;
  logic        cond_flag, invalid_pulse;
  logic [31:0] stat_out;

  int n_chk = 0, n_fail = 0;
  logic        m_flag = 1'b0, m_inv = 1'b0;
  logic [31:0] m_stat = '0;

  always #2 clk = ~clk;

  fp_cmp_pred i_fp_cmp_pred (
    .clk(clk), .rst_n(rst_n), .cmp_valid(cmp_valid), .dbl_sel(dbl_sel),
    .pred_code(pred_code), .opa(opa), .opb(opb), .stat_keep(stat_keep),
    .cond_flag(cond_flag), .stat_out(stat_out), .invalid_pulse(invalid_pulse));

  function automatic real sp_val(logic [31:0] x);
    int  e = int'(x[30:23]);
    real m;
    if (e == 0) m = (x[22:0] / 8388608.0) * (2.0 ** (-126));
    else        m = (1.0 + x[22:0] / 8388608.0) * (2.0 ** (e - 127));
    return x[31] ? -m : m;
  endfunction

  function automatic bit is_nan(logic [63:0] x, logic d);
    return d ? (x[62:52] == 11'h7FF && x[51:0] != 0) : (x[30:23] == 8'hFF && x[22:0] != 0);
  endfunction

  function automatic bit is_snan(logic [63:0] x, logic d);
    return is_nan(x, d) && !(d ? x[51] : x[22]);
  endfunction

  // 0 less, 1 equal, 2 greater, 3 unordered
  function automatic int relation(logic [63:0] a, logic [63:0] b, logic d);
    real ra, rb;
    if (is_nan(a, d) || is_nan(b, d)) return 3;
    ra = d ? $bitstoreal(a) : sp_val(a[31:0]);
    rb = d ? $bitstoreal(b) : sp_val(b[31:0]);
    if (ra < rb) return 0;
    if (ra == rb) return 1;
    return 2;
  endfunction

  function automatic bit pred_holds(int r, logic [2:0] p);
    bit un = (r == 3), eq = (r == 1), lt = (r == 0);
    case (p)
      3'd0: return 0;
      3'd1: return un;
      3'd2: return eq;
      3'd3: return un || eq;
      3'd4: return lt;
      3'd5: return un || lt;
      3'd6: return lt || eq;
      default: return r != 2;
    endcase
  endfunction

  task automatic check(string tag);
    n_chk++;
    if (cond_flag !== m_flag || stat_out !== m_stat || invalid_pulse !== m_inv) begin
      n_fail++;
      $display("FAIL %s: flag=%0b/%0b stat=%h/%h inv=%0b/%0b (actual/expected)",
               tag, cond_flag, m_flag, stat_out, m_stat, invalid_pulse, m_inv);
    end
  endtask

  task automatic run(logic [63:0] a, logic [63:0] b, logic d, logic [2:0] p,
                     logic [27:0] k, logic v, string tag);
    bit h;
    opa = a; opb = b; dbl_sel = d; pred_code = p; stat_keep = k; cmp_valid = v;
    if (v) begin
      h = pred_holds(relation(a, b, d), p);
      m_flag = h;
      m_stat = {2'b00, h, 1'b0, k};
      m_inv  = is_snan(a, d) || is_snan(b, d);
    end else m_inv = 1'b0;
    @(negedge clk);
    check(tag);
  endtask

  localparam logic [31:0] S1 = 32'h3F800000, S2 = 32'h40000000, SN1 = 32'hBF800000,
                          SN2 = 32'hC0000000, SPZ = 32'h0, SNZ = 32'h80000000,
                          SQN = 32'h7FC00000, SSN = 32'h7F800001, SINF = 32'h7F800000;
  localparam logic [63:0] D1 = 64'h3FF0000000000000, D2 = 64'h4000000000000000,
                          DN1 = 64'hBFF0000000000000, DN2 = 64'hC000000000000000,
                          DNZ = 64'h8000000000000000, DQN = 64'h7FF8000000000000,
                          DSN = 64'h7FF0000000000001;

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: run did not finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [63:0] sp_pool [9];
    logic [63:0] dp_pool [8];
    sp_pool = '{S1, S2, SN1, SN2, SPZ, SNZ, SQN, SSN, SINF};
    dp_pool = '{D1, D2, DN1, DN2, 64'd0, DNZ, DQN, DSN};
    rst_n = 1'b0; cmp_valid = 1'b0; dbl_sel = 1'b0; pred_code = '0;
    opa = '0; opb = '0; stat_keep = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 in reset");
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after release");

    for (int p = 0; p < 8; p++) begin
      run({32'd0, S1},  {32'd0, S2},  1'b0, 3'(p), 28'hABCDEF1, 1'b1, "R3 single less");
      run({32'd0, S2},  {32'd0, S1},  1'b0, 3'(p), 28'h1234567, 1'b1, "R3 single greater");
      run({32'd0, S1},  {32'd0, S1},  1'b0, 3'(p), 28'h0FFFFFF, 1'b1, "R3 single equal");
      run({32'd0, SQN}, {32'd0, S1},  1'b0, 3'(p), 28'h5555555, 1'b1, "R3 single unordered");
      run(D1, D2, 1'b1, 3'(p), 28'hFFFFFFF, 1'b1, "R3 double less");
      run(DQN, D1, 1'b1, 3'(p), 28'h0000001, 1'b1, "R3 double unordered");
    end

    run({32'd0, SPZ}, {32'd0, SNZ}, 1'b0, 3'd2, 28'h1, 1'b1, "R2 +0 == -0 single");
    run(64'd0, DNZ, 1'b1, 3'd2, 28'h2, 1'b1, "R2 +0 == -0 double");
    run(DN2, DN1, 1'b1, 3'd4, 28'h3, 1'b1, "R7 -2 < -1 double");
    run({32'd0, SN1}, {32'd0, SN2}, 1'b0, 3'd4, 28'h4, 1'b1, "R7 -1 not < -2 single");
    run({32'd0, SN1}, {32'd0, S1}, 1'b0, 3'd6, 28'h5, 1'b1, "R7 negative below positive");

    run({32'd0, SSN}, {32'd0, S1}, 1'b0, 3'd1, 28'h6, 1'b1, "R5 single sNaN a");
    run(D1, DSN, 1'b1, 3'd5, 28'h7, 1'b1, "R5 double sNaN b");
    run(DQN, DQN, 1'b1, 3'd3, 28'h8, 1'b1, "R5 quiet NaN no pulse");
    run(DSN, D1, 1'b1, 3'd1, 28'h9, 1'b1, "R5 sNaN back to back");
    run(D1, D1, 1'b1, 3'd2, 28'hA, 1'b0, "R8 hold, pulse drops");

    run({32'hDEADBEEF, S1}, {32'h7FF80000, S2}, 1'b0, 3'd4, 28'hB, 1'b1, "R6 upper bits ignored");
    run({32'hFFFFFFFF, S2}, {32'h00000000, S2}, 1'b0, 3'd2, 28'hC, 1'b1, "R6 upper bits ignored eq");

    run(D2, D1, 1'b1, 3'd7, 28'hD, 1'b0, "R8 no strobe hold");
    run({32'd0, S1}, {32'd0, S1}, 1'b0, 3'd2, 28'hE, 1'b1, "R8 strobe updates");

    for (int i = 0; i < 300; i++) begin
      logic d = 1'($urandom_range(0, 1));
      logic [63:0] a = d ? dp_pool[$urandom_range(0, 7)] : sp_pool[$urandom_range(0, 8)];
      logic [63:0] b = d ? dp_pool[$urandom_range(0, 7)] : sp_pool[$urandom_range(0, 8)];
      if (!d) begin
        a[63:32] = $urandom;
        b[63:32] = $urandom;
      end
      run(a, b, d, 3'($urandom_range(0, 7)), 28'($urandom),
          1'($urandom_range(0, 3) != 0), "R4 random mix");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule